// File: doc/BRIEF.md
# Module-Decoded Destructive-Readout Memory

This block is a small word memory made of four equal storage modules behind an 8-bit word address. The two top address bits choose one module, and the low six bits reach every module as a row and column coordinate. Only the chosen module acts on that coordinate. Each module behaves like destructive storage: reading a word wipes the cell, so the controller always follows a read with an automatic rewrite of the captured word before it takes another request.

A client raises a request with an address, a read/write select and write data. It holds these steady until the block pulses an acknowledge. Read data is presented on the acknowledge cycle and kept until a later read replaces it.

Top module: `dro_mem_top`

## Requirements
- R1: Address bits [7:6] select the module, bits [5:3] the row and bits [2:0] the column; address 8'o372 reaches module 3, local word 8'o72 (row 7, column 2).
- R2: An access changes no word in any module other than the one its address bits [7:6] select, even at the same local address.
- R3: A write (we_i=1) stores wdata_i at the addressed word; a later read of that address returns it, and rdata_o is left unchanged by the write.
- R4: Counting the accepting rising edge as the first, ack_o is high between the third and fourth edges for a read and between the second and third edges for a write.
- R5: A read clears the addressed cell and then rewrites the captured word, so repeated reads of one address keep returning the same value.
- R6: ack_o is high for exactly one clock cycle per accepted request.
- R7: A request is accepted only while the block is idle; a request held high through the acknowledge starts its next operation two edges after the acknowledge edge, so back-to-back reads ack four cycles apart.
- R8: rdata_o carries the read word on the acknowledge cycle and holds it until the next read captures new data.
- R9: After reset ack_o is low, rdata_o is zero and every stored word reads as zero.

Remaining: `dro_mem_top` ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address: module, row, column |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | DATA_W | Read data, valid from acknowledge |

## Verification
The restore write of one read and the acceptance of the next request can fall in adjacent cycles, touching the same cell. The bench holds a read request high across the acknowledge and checks that the second read of the same word, accepted as soon as the block is idle again, returns the restored value with the R7 spacing. Random reads and writes across all four modules are compared against a bench model, which also catches a restore that goes to the wrong module.

// File: rtl/dro_mem_pkg.sv
package dro_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_RESTORE = 3'd2,
    ST_WRITE   = 3'd3,
    ST_ACK     = 3'd4
  } seq_state_e;
endpackage

// File: rtl/dro_sel_dec.sv
module dro_sel_dec #(
  parameter int SEL_W = 2,
  localparam int NMOD = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic [NMOD-1:0]  onehot_o
);
  for (genvar g = 0; g < NMOD; g++) begin : g_dec
    assign onehot_o[g] = en_i && (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/dro_bank.sv
module dro_bank #(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  localparam int ROWS  = 1 << ROW_W,
  localparam int COLS  = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              rd_clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cell_q [ROWS][COLS];

  assign rdata_o = cell_q[row_i][col_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cell_q[r][c] <= '0;
    end else if (wr_i) begin
      cell_q[row_i][col_i] <= wdata_i;
    end else if (rd_clr_i) begin
      cell_q[row_i][col_i] <= '0; // destructive readout
    end
  end

  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !wr_i) |=> cell_q[$past(row_i)][$past(col_i)] == '0);

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cell_q[$past(row_i)][$past(col_i)] == $past(wdata_i));
endmodule

// File: rtl/dro_seq.sv
module dro_seq
  import dro_mem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = we_i ? ST_WRITE : ST_READ;
      ST_READ:    state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_ACK;
      ST_WRITE:   state_d = ST_ACK;
      ST_ACK:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r5_restore_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ) |=> (state_q == ST_RESTORE));

  a_r7_ack_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dro_mem_top.sv
module dro_mem_top
  import dro_mem_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  localparam int ADDR_W = SEL_W + ROW_W + COL_W,
  localparam int NMOD   = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, bank_wdata;
  logic              rd_clr, wr, accept;
  logic [NMOD-1:0]   bank_en;
  logic [DATA_W-1:0] bank_rd [NMOD];

  wire [SEL_W-1:0] mod_idx = addr_q[ADDR_W-1 -: SEL_W];
  wire [ROW_W-1:0] row     = addr_q[COL_W +: ROW_W];
  wire [COL_W-1:0] col     = addr_q[COL_W-1:0];

  dro_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .state_o(state)
  );

  assign accept     = (state == ST_IDLE) && req_i;
  assign rd_clr     = (state == ST_READ);
  assign wr         = (state == ST_RESTORE) || (state == ST_WRITE);
  assign bank_wdata = (state == ST_RESTORE) ? rdata_q : wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_clr) rdata_q <= bank_rd[mod_idx];
  end

  dro_sel_dec #(.SEL_W(SEL_W)) u_dec (
    .sel_i   (mod_idx),
    .en_i    (rd_clr || wr),
    .onehot_o(bank_en)
  );

  for (genvar g = 0; g < NMOD; g++) begin : g_bank
    dro_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .row_i   (row),
      .col_i   (col),
      .rd_clr_i(bank_en[g] && rd_clr),
      .wr_i    (bank_en[g] && wr),
      .wdata_i (bank_wdata),
      .rdata_o (bank_rd[g])
    );
  end

  assign ack_o   = (state == ST_ACK);
  assign rdata_o = rdata_q;

  a_r2_one_module: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_en));

  a_r6_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r8_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> $stable(rdata_o));

  a_r1_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |=> $stable(addr_q));
endmodule

// File: tb/sim_dro_mem_top.sv
module sim_dro_mem_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack;
  logic [DW-1:0] rdata;

  int total = 0, bad = 0;
  logic [DW-1:0] model [256];
  logic [DW-1:0] last_rd = '0;

  always #10 clk = ~clk; // 50 MHz

  dro_mem_top #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata)
  );

  function automatic int exp_lat(input logic w);
    return w ? 2 : 3;
  endfunction

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // issue one request, wait for ack, check latency/data, then release
  task automatic op(input logic w, input logic [7:0] a, input logic [DW-1:0] d, input bit hold);
    int n = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 20);
    chk("R4 latency", DW'(n), DW'(exp_lat(w)));
    if (w) begin
      model[a] = d;
      chk("R3 rdata unchanged by write", rdata, last_rd);
    end else begin
      chk("R8 read data on ack", rdata, model[a]);
      last_rd = model[a];
    end
    if (!hold) begin
      req = 1'b0;
      @(negedge clk);
      chk("R6 ack one cycle", DW'(ack), '0);
      chk("R8 rdata held", rdata, last_rd);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R9 ack low in reset", DW'(ack), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ack low after reset", DW'(ack), '0);
    chk("R9 rdata zero", rdata, '0);
    op(1'b0, 8'o155, '0, 1'b0); // R9 memory zero

    // R1: 8'o372 -> module 3, local 072; neighbours with same local bits untouched (R2)
    op(1'b1, 8'o372, 16'hbeef, 1'b0);
    op(1'b0, 8'o072, '0, 1'b0);
    op(1'b0, 8'o172, '0, 1'b0);
    op(1'b0, 8'o272, '0, 1'b0);
    op(1'b0, 8'o372, '0, 1'b0);
    chk("R1 module 3 word 072", rdata, 16'hbeef);
    op(1'b1, 8'o072, 16'h1234, 1'b0);
    op(1'b0, 8'o372, '0, 1'b0);
    chk("R2 module 3 untouched", rdata, 16'hbeef);

    // R5: repeated reads return same word
    op(1'b0, 8'o372, '0, 1'b0);
    chk("R5 restore after read", rdata, 16'hbeef);

    // R7: held request, back-to-back reads of same word
    op(1'b0, 8'o372, '0, 1'b1);
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!ack && n < 20);
      chk("R7 back-to-back spacing", DW'(n), DW'(4));
      chk("R7 restored word on second read", rdata, 16'hbeef);
      req = 1'b0;
      @(negedge clk);
    end

    // corners: all-ones data, extreme addresses
    op(1'b1, 8'o000, '1, 1'b0);
    op(1'b1, 8'o377, 16'h8001, 1'b0);
    op(1'b0, 8'o000, '0, 1'b0);
    op(1'b0, 8'o377, '0, 1'b0);

    // random mix, R2/R3/R5 against the model
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a = 8'($urandom_range(0, 255));
      op(1'($urandom_range(0, 1)), a, DW'($urandom), 1'b0);
    end
    for (int a = 0; a < 256; a += 7) op(1'b0, 8'(a), '0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule